// File: doc/BRIEF.md
# Header Nonce Scanner

The scanner searches a range of nonces for the lowest hash of an 80-byte block header. The host loads nineteen header words, the upper 64 bits of a 256-bit target, a base nonce and a nonce count through a small word-wide write port, then pulses `start`. For each candidate nonce the block runs an eight-round ARX compression over a padded second message block. Each candidate whose top 64-bit result word is at or below the target is a qualifying candidate. The lowest qualifying result is kept, together with the nonce that produced it.

The header is 64 + 16 bytes long, so the first 64-byte block does not depend on the nonce. Its chaining value is computed once and cached. The cache is refreshed only after one of the first sixteen header words has been rewritten. Header word 19 takes the candidate nonce in every hash, so it is not stored.

A single compression core is time-shared. It does one half-round per cycle: four mixing functions that run in parallel on either the columns or the diagonals of the 4×4 state.

Top module: `hdr_nonce_scanner`

## Requirements
- R1: Block one is header words 0–15, compressed in 8 rounds. It starts from the chaining value 6A09E667, BB67AE85, 3C6EF372, A54FF53A, 510E527F, 9B05688C, 1F83D9AB, 5BE0CD19 (hex), with all salt words zero, counter high 0 and counter low 512.
- R2: Block two has 16 message words: header words 16, 17 and 18 in positions 0–2, the candidate nonce in position 3, 80000000h in position 4, zero in positions 5–12, 1 in position 13, 0 in position 14 and 640 in position 15. It is compressed from the cached block-one value with counter low 640 and counter high 0.
- R3: In `best_hash`, bits [32i+31:32i] hold the final chaining word i with its four bytes reversed. The 64-bit result word three is `best_hash[255:192]`.
- R4: A candidate qualifies when its bits [255:192] are less than or equal to the target {address 21 value, address 20 value}, compared as an unsigned 64-bit number.
- R5: A qualifying candidate replaces the stored result only when its bits [255:192] are strictly below the stored bits [255:192]. When it does, `best_nonce` takes its nonce in the same cycle.
- R6: Reset and every accepted `start` set `best_hash` and `best_nonce` to all ones. Both stay all ones through a scan in which no candidate qualifies.
- R7: `found` is cleared by reset and by an accepted `start`. It rises when any candidate of the scan qualifies and holds until the next accepted `start`.
- R8: `start` is accepted only while `busy` is low. The edge that accepts it clears `done` and raises `busy`. Let k be the number of compressions the scan needs. Then `done` rises and `busy` falls 18·k+1 cycles after the accepting edge, and `done` stays high until the next accepted `start`.
- R9: Writing any of header words 0–15 marks the cached block-one value stale. A scan computes block one first (one extra compression) only when the value is stale. Writes to words 16–18 leave it valid.
- R10: Writes set header words 0–18 at addresses 0–18. Address 20 sets the target low half, 21 the target high half, 22 the base nonce and 23 the count. Writes to address 19 or 24–31, and any write while `busy` is high, have no effect.
- R11: A scan with count zero computes no candidates. It ends with `found` low and the result at all ones.
- R12: Candidate i uses nonce base + i modulo 2^32, for i from 0 to count−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Begin a scan (accepted while idle) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, result valid |
| found | output | 1 | At least one candidate qualified |
| best_hash | output | 256 | Lowest qualifying result, byte-swapped words |
| best_nonce | output | 32 | Nonce of `best_hash` |

## Verification
Each compression takes 18 cycles: one dispatch cycle, a load cycle, sixteen half-round cycles, and the final combine, which is consumed on the next edge. One more cycle latches `done`, so every scan result is due exactly 18·k+1 cycles after the start edge. The bench counts falling edges from that start edge and requires `done` to appear on exactly that count. This ties the cache behaviour (k = count or count+1) to a cycle number. `found`, `best_hash` and `best_nonce` are sampled at that same falling edge and compared with a bench-side model of both compressions. Writes made during a scan are driven on falling edges while `busy` is known high, and their absence of effect is read back through the following scans' results and latencies.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
   typedef logic [31:0] word_t;

   localparam int    CFG_AW     = 5;
   localparam int    HDR_KEPT   = 19;
   localparam int    BLK_WORDS  = 16;
   localparam int    CV_WORDS   = 8;
   localparam int    RES_W      = 32 * CV_WORDS;
   localparam word_t LEN_BLK1   = 32'd512;
   localparam word_t LEN_BLK2   = 32'd640;
   localparam int    A_TGT_LO   = 20;
   localparam int    A_TGT_HI   = 21;
   localparam int    A_BASE     = 22;
   localparam int    A_COUNT    = 23;

   function automatic word_t ror32(input word_t x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic word_t bswap32(input word_t x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   function automatic word_t iv_word(input logic [2:0] i);
      case (i)
         3'd0: return 32'h6A09E667;
         3'd1: return 32'hBB67AE85;
         3'd2: return 32'h3C6EF372;
         3'd3: return 32'hA54FF53A;
         3'd4: return 32'h510E527F;
         3'd5: return 32'h9B05688C;
         3'd6: return 32'h1F83D9AB;
         default: return 32'h5BE0CD19;
      endcase
   endfunction

   function automatic word_t pi_word(input logic [3:0] i);
      case (i)
         4'h0: return 32'h243F6A88;
         4'h1: return 32'h85A308D3;
         4'h2: return 32'h13198A2E;
         4'h3: return 32'h03707344;
         4'h4: return 32'hA4093822;
         4'h5: return 32'h299F31D0;
         4'h6: return 32'h082EFA98;
         4'h7: return 32'hEC4E6C89;
         4'h8: return 32'h452821E6;
         4'h9: return 32'h38D01377;
         4'hA: return 32'hBE5466CF;
         4'hB: return 32'h34E90C6C;
         4'hC: return 32'hC0AC29B7;
         4'hD: return 32'hC97C50DD;
         4'hE: return 32'h3F84D5B5;
         default: return 32'hB5470917;
      endcase
   endfunction

   // message schedule: row r, slot k (slot 0 in the top nibble)
   function automatic logic [3:0] perm_idx(input logic [3:0] r, input logic [3:0] k);
      logic [63:0] row;
      logic [3:0]  rr;
      rr = (r >= 4'd10) ? r - 4'd10 : r;
      case (rr)
         4'd0: row = 64'h0123456789ABCDEF;
         4'd1: row = 64'hEA489FD61C02B753;
         4'd2: row = 64'hB8C052FDAE367194;
         4'd3: row = 64'h7931DCBE265A40F8;
         4'd4: row = 64'h905724AFE1BC683D;
         4'd5: row = 64'h2C6A0B834D75FE19;
         4'd6: row = 64'hC51FED4A0763928B;
         4'd7: row = 64'hDB7EC13950F4862A;
         4'd8: row = 64'h6FE9B308C2D714A5;
         default: row = 64'hA2847615FB9E3CD0;
      endcase
      return row[{~k, 2'b00} +: 4];
   endfunction
endpackage

// File: rtl/nsc_gmix.sv
module nsc_gmix
   import nsc_pkg::*;
(
   input  word_t a_i,
   input  word_t b_i,
   input  word_t c_i,
   input  word_t d_i,
   input  word_t m0_i,
   input  word_t m1_i,
   input  word_t k0_i,
   input  word_t k1_i,
   output word_t a_o,
   output word_t b_o,
   output word_t c_o,
   output word_t d_o
);
   word_t a1, b1, c1, d1;

   always_comb begin
      a1  = a_i + b_i + (m0_i ^ k1_i);
      d1  = ror32(d_i ^ a1, 16);
      c1  = c_i + d1;
      b1  = ror32(b_i ^ c1, 12);
      a_o = a1 + b1 + (m1_i ^ k0_i);
      d_o = ror32(d1 ^ a_o, 8);
      c_o = c1 + d_o;
      b_o = ror32(b1 ^ c_o, 7);
   end
endmodule

// File: rtl/nsc_core.sv
module nsc_core
   import nsc_pkg::*;
#(
   parameter int ROUNDS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [CV_WORDS-1:0][31:0]     h_in,
   input  logic [BLK_WORDS-1:0][31:0]    msg,
   input  word_t                         t_lo,
   output logic                          done,
   output logic [CV_WORDS-1:0][31:0]     h_out
);
   localparam int NSTEP = 2 * ROUNDS;
   localparam int SW    = $clog2(NSTEP + 1);
   localparam logic [SW-1:0] LAST = SW'(NSTEP);

   logic [15:0][31:0]          v, v_next;
   logic [BLK_WORDS-1:0][31:0] m;
   logic [CV_WORDS-1:0][31:0]  h;
   logic                       run;
   logic [SW-1:0]              step;
   logic                       diag;
   logic [3:0]                 rnd;
   word_t ga [4], gb [4], gc [4], gd [4];

   assign diag = step[0];
   assign rnd  = 4'(step >> 1);

   // four lanes per half-round; diagonal lanes rotate b, c, d by 1, 2, 3
   for (genvar gi = 0; gi < 4; gi++) begin : g_lane
      logic [3:0] s0, s1;
      assign s0 = perm_idx(rnd, diag ? 4'(8 + 2*gi) : 4'(2*gi));
      assign s1 = perm_idx(rnd, diag ? 4'(9 + 2*gi) : 4'(2*gi + 1));
      nsc_gmix u_mix (
         .a_i  (v[gi]),
         .b_i  (diag ? v[4 + ((gi+1)%4)]  : v[4 + gi]),
         .c_i  (diag ? v[8 + ((gi+2)%4)]  : v[8 + gi]),
         .d_i  (diag ? v[12 + ((gi+3)%4)] : v[12 + gi]),
         .m0_i (m[s0]),
         .m1_i (m[s1]),
         .k0_i (pi_word(s0)),
         .k1_i (pi_word(s1)),
         .a_o  (ga[gi]),
         .b_o  (gb[gi]),
         .c_o  (gc[gi]),
         .d_o  (gd[gi])
      );
   end

   always_comb begin
      v_next = v;
      for (int g = 0; g < 4; g++) begin
         v_next[g] = ga[g];
         v_next[diag ? 4'(4 + (g+1)%4)  : 4'(4 + g)]  = gb[g];
         v_next[diag ? 4'(8 + (g+2)%4)  : 4'(8 + g)]  = gc[g];
         v_next[diag ? 4'(12 + (g+3)%4) : 4'(12 + g)] = gd[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= 1'b0;
         step <= '0;
         v    <= '0;
         m    <= '0;
         h    <= '0;
      end else if (start) begin
         for (int i = 0; i < 8; i++) v[i] <= h_in[i];
         for (int i = 0; i < 4; i++) v[8+i] <= pi_word(4'(i));
         v[12] <= t_lo ^ pi_word(4'd4);
         v[13] <= t_lo ^ pi_word(4'd5);
         v[14] <= pi_word(4'd6);
         v[15] <= pi_word(4'd7);
         m     <= msg;
         h     <= h_in;
         run   <= 1'b1;
         step  <= '0;
      end else if (run) begin
         if (step == LAST) begin
            run <= 1'b0;
         end else begin
            v    <= v_next;
            step <= step + 1'b1;
         end
      end
   end

   assign done = run && (step == LAST);

   always_comb
      for (int i = 0; i < CV_WORDS; i++) h_out[i] = h[i] ^ v[i] ^ v[i+8];

   // R8: the controller only launches a compression on an idle core
   a_r8_core_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run);
endmodule

// File: rtl/nsc_best.sv
module nsc_best
   import nsc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cand_vld,
   input  logic [RES_W-1:0] cand_hash,
   input  word_t            cand_nonce,
   input  logic [63:0]      tgt_top,
   output logic             found,
   output logic [RES_W-1:0] best_hash,
   output word_t            best_nonce
);
   logic [63:0] cand_top, best_top;
   logic        qual;

   assign cand_top = cand_hash[RES_W-1 -: 64];
   assign best_top = best_hash[RES_W-1 -: 64];
   assign qual     = cand_vld && (cand_top <= tgt_top);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         found      <= 1'b0;
         best_hash  <= '1;
         best_nonce <= '1;
      end else if (qual) begin
         found <= 1'b1;
         if (cand_top < best_top) begin
            best_hash  <= cand_hash;
            best_nonce <= cand_nonce;
         end
      end
   end

   a_r5_best_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (best_top <= $past(best_top)));
   a_r7_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (found && !clr) |=> found);
   a_r4_replace_within_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cand_vld) |=> (best_top == $past(best_top)) || (best_top <= $past(tgt_top)));
endmodule

// File: rtl/hdr_nonce_scanner.sv
module hdr_nonce_scanner
   import nsc_pkg::*;
#(
   parameter int ROUNDS = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [RES_W-1:0]  best_hash,
   output logic [31:0]       best_nonce
);
   if (ROUNDS < 1 || ROUNDS > 14) begin : g_bad_rounds
      $error("ROUNDS must lie in 1..14");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end

   typedef enum logic [1:0] {S_IDLE, S_DISP, S_BLK1, S_BLK2} st_t;

   st_t                        state;
   logic [HDR_KEPT-1:0][31:0]  hdr;
   logic [CV_WORDS-1:0][31:0]  cv, iv_cv, core_hin, core_h;
   logic [BLK_WORDS-1:0][31:0] blk2, core_msg;
   word_t                      tgt_lo, tgt_hi, base, cur_nonce, core_t;
   logic [CNT_W-1:0]           cnt, idx;
   logic                       cv_ok, core_go, core_done, scan_clr, cand_vld;
   logic [RES_W-1:0]           cand_hash;

   assign cur_nonce = base + 32'(idx);
   assign core_go   = (state == S_DISP) && (!cv_ok || idx != cnt);
   assign scan_clr  = (state == S_IDLE) && start;
   assign cand_vld  = (state == S_BLK2) && core_done;

   always_comb begin
      for (int i = 0; i < CV_WORDS; i++) iv_cv[i] = iv_word(3'(i));
      blk2     = '0;
      blk2[0]  = hdr[16];
      blk2[1]  = hdr[17];
      blk2[2]  = hdr[18];
      blk2[3]  = cur_nonce;
      blk2[4]  = 32'h8000_0000;
      blk2[13] = 32'h0000_0001;
      blk2[15] = LEN_BLK2;
      core_msg = cv_ok ? blk2 : hdr[BLK_WORDS-1:0];
      core_hin = cv_ok ? cv : iv_cv;
      core_t   = cv_ok ? LEN_BLK2 : LEN_BLK1;
      for (int i = 0; i < CV_WORDS; i++) cand_hash[32*i +: 32] = bswap32(core_h[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         hdr    <= '0;
         cv     <= '0;
         cv_ok  <= 1'b0;
         tgt_lo <= '0;
         tgt_hi <= '0;
         base   <= '0;
         cnt    <= '0;
         idx    <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         if (cfg_we && !busy) begin
            if (cfg_addr < CFG_AW'(HDR_KEPT)) begin
               hdr[cfg_addr] <= cfg_wdata;
               if (cfg_addr < CFG_AW'(BLK_WORDS)) cv_ok <= 1'b0;
            end
            if (cfg_addr == CFG_AW'(A_TGT_LO)) tgt_lo <= cfg_wdata;
            if (cfg_addr == CFG_AW'(A_TGT_HI)) tgt_hi <= cfg_wdata;
            if (cfg_addr == CFG_AW'(A_BASE))   base   <= cfg_wdata;
            if (cfg_addr == CFG_AW'(A_COUNT))  cnt    <= cfg_wdata[CNT_W-1:0];
         end
         case (state)
            S_IDLE: if (start) begin
               busy  <= 1'b1;
               done  <= 1'b0;
               idx   <= '0;
               state <= S_DISP;
            end
            S_DISP: begin
               if (!cv_ok)          state <= S_BLK1;
               else if (idx != cnt) state <= S_BLK2;
               else begin
                  busy  <= 1'b0;
                  done  <= 1'b1;
                  state <= S_IDLE;
               end
            end
            S_BLK1: if (core_done) begin
               cv    <= core_h;
               cv_ok <= 1'b1;
               state <= S_DISP;
            end
            default: if (core_done) begin
               idx   <= idx + 1'b1;
               state <= S_DISP;
            end
         endcase
      end
   end

   nsc_core #(.ROUNDS(ROUNDS)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .start (core_go),
      .h_in  (core_hin),
      .msg   (core_msg),
      .t_lo  (core_t),
      .done  (core_done),
      .h_out (core_h)
   );

   nsc_best u_best (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (scan_clr),
      .cand_vld   (cand_vld),
      .cand_hash  (cand_hash),
      .cand_nonce (cur_nonce),
      .tgt_top    ({tgt_hi, tgt_lo}),
      .found      (found),
      .best_hash  (best_hash),
      .best_nonce (best_nonce)
   );

   a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   a_r10_hdr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(hdr));
endmodule

// File: tb/hdr_nonce_scanner_tb.sv
`timescale 1ns/1ps
module hdr_nonce_scanner_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [4:0]   cfg_addr = '0;
   logic [31:0]  cfg_wdata = '0;
   logic         start = 1'b0;
   logic         busy, done, found;
   logic [255:0] best_hash;
   logic [31:0]  best_nonce;

   int nchk = 0;
   int nerr = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   hdr_nonce_scanner u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .done(done),
      .found(found), .best_hash(best_hash), .best_nonce(best_nonce)
   );

   // ---------------- independent model ----------------
   logic [31:0] hm [19];
   logic [31:0] tlo, thi, bs;
   int          cn;

   function automatic logic [31:0] rr(logic [31:0] x, int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic logic [31:0] mc(int i);
      case (i)
         0: return 32'h243F6A88;  1: return 32'h85A308D3;
         2: return 32'h13198A2E;  3: return 32'h03707344;
         4: return 32'hA4093822;  5: return 32'h299F31D0;
         6: return 32'h082EFA98;  7: return 32'hEC4E6C89;
         8: return 32'h452821E6;  9: return 32'h38D01377;
         10: return 32'hBE5466CF; 11: return 32'h34E90C6C;
         12: return 32'hC0AC29B7; 13: return 32'hC97C50DD;
         14: return 32'h3F84D5B5; default: return 32'hB5470917;
      endcase
   endfunction

   function automatic logic [63:0] mrow(int r);
      case (r)
         0: return 64'h0123456789ABCDEF;
         1: return 64'hEA489FD61C02B753;
         2: return 64'hB8C052FDAE367194;
         3: return 64'h7931DCBE265A40F8;
         4: return 64'h905724AFE1BC683D;
         5: return 64'h2C6A0B834D75FE19;
         6: return 64'hC51FED4A0763928B;
         default: return 64'hDB7EC13950F4862A;
      endcase
   endfunction

   function automatic logic [7:0][31:0] mcomp(logic [7:0][31:0] h,
                                              logic [15:0][31:0] m, logic [31:0] t);
      logic [15:0][31:0] v;
      logic [7:0][31:0]  o;
      for (int i = 0; i < 8; i++) v[i] = h[i];
      for (int i = 0; i < 4; i++) v[8+i] = mc(i);
      v[12] = t ^ mc(4); v[13] = t ^ mc(5); v[14] = mc(6); v[15] = mc(7);
      for (int r = 0; r < 8; r++) begin
         for (int j = 0; j < 8; j++) begin
            int s0, s1, a, b, c, d, q;
            s0 = int'(mrow(r) >> (60 - 8*j)) & 15;
            s1 = int'(mrow(r) >> (56 - 8*j)) & 15;
            q = j % 4;
            a = q;
            b = (j < 4) ? 4 + q  : 4 + (q+1)%4;
            c = (j < 4) ? 8 + q  : 8 + (q+2)%4;
            d = (j < 4) ? 12 + q : 12 + (q+3)%4;
            v[a] = v[a] + v[b] + (m[s0] ^ mc(s1));
            v[d] = rr(v[d] ^ v[a], 16);
            v[c] = v[c] + v[d];
            v[b] = rr(v[b] ^ v[c], 12);
            v[a] = v[a] + v[b] + (m[s1] ^ mc(s0));
            v[d] = rr(v[d] ^ v[a], 8);
            v[c] = v[c] + v[d];
            v[b] = rr(v[b] ^ v[c], 7);
         end
      end
      for (int i = 0; i < 8; i++) o[i] = h[i] ^ v[i] ^ v[i+8];
      return o;
   endfunction

   function automatic logic [255:0] mhash(logic [31:0] nonce);
      logic [7:0][31:0]  iv, cv, hh;
      logic [15:0][31:0] b1, b2;
      logic [255:0]      r;
      iv = {32'h5BE0CD19, 32'h1F83D9AB, 32'h9B05688C, 32'h510E527F,
            32'hA54FF53A, 32'h3C6EF372, 32'hBB67AE85, 32'h6A09E667};
      for (int i = 0; i < 16; i++) b1[i] = hm[i];
      cv = mcomp(iv, b1, 32'd512);
      b2 = '0;
      b2[0] = hm[16]; b2[1] = hm[17]; b2[2] = hm[18]; b2[3] = nonce;
      b2[4] = 32'h80000000; b2[13] = 32'd1; b2[15] = 32'd640;
      hh = mcomp(cv, b2, 32'd640);
      for (int i = 0; i < 8; i++)
         r[32*i +: 32] = {hh[i][7:0], hh[i][15:8], hh[i][23:16], hh[i][31:24]};
      return r;
   endfunction

   task automatic expect_scan(output logic ef, output logic [255:0] eh, output logic [31:0] en);
      logic [255:0] x;
      ef = 0; eh = '1; en = '1;
      for (int i = 0; i < cn; i++) begin
         x = mhash(bs + 32'(i));
         if (x[255:192] <= {thi, tlo}) begin
            ef = 1;
            if (x[255:192] < eh[255:192]) begin eh = x; en = bs + 32'(i); end
         end
      end
   endtask

   // lowest and second-lowest top word over the current range
   task automatic low_two(output logic [63:0] lo1, output logic [63:0] lo2);
      logic [255:0] x;
      lo1 = '1; lo2 = '1;
      for (int i = 0; i < cn; i++) begin
         x = mhash(bs + 32'(i));
         if (x[255:192] < lo1) begin lo2 = lo1; lo1 = x[255:192]; end
         else if (x[255:192] < lo2) lo2 = x[255:192];
      end
   endtask

   // ---------------- bench utilities ----------------
   task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_regs();
      for (int i = 0; i < 19; i++) wr(i, hm[i]);
      wr(20, tlo); wr(21, thi); wr(22, bs); wr(23, 32'(cn));
   endtask

   // k = compressions expected; poke = write registers while busy
   task automatic scan(string tag, int k, bit poke);
      int cyc;
      logic ef; logic [255:0] eh; logic [31:0] en;
      expect_scan(ef, eh, en);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      chk({tag, " R8 busy after start"}, 256'(busy), 256'(1));
      while (!done && cyc < 2000) begin
         if (poke) begin
            case (cyc)
               0: begin cfg_we = 1; cfg_addr = 5'd0;  cfg_wdata = ~hm[0];  end
               1: begin cfg_we = 1; cfg_addr = 5'd16; cfg_wdata = ~hm[16]; end
               2: begin cfg_we = 1; cfg_addr = 5'd21; cfg_wdata = 32'h0;   end
               3: begin cfg_we = 1; cfg_addr = 5'd23; cfg_wdata = 32'h0;   end
               default: cfg_we = 0;
            endcase
         end
         @(negedge clk);
         cfg_we = 0;
         cyc++;
      end
      chk({tag, " R8 latency"}, 256'(cyc), 256'(18*k + 1));
      chk({tag, " R8 busy low at done"}, 256'(busy), 256'(0));
      chk({tag, " R7 found"}, 256'(found), 256'(ef));
      chk({tag, " R3 R5 best_hash"}, best_hash, eh);
      chk({tag, " R5 best_nonce"}, 256'(best_nonce), 256'(en));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nerr++; nchk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] lo1, lo2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset busy", 256'(busy), 256'(0));
      chk("R8 reset done", 256'(done), 256'(0));
      chk("R7 reset found", 256'(found), 256'(0));
      chk("R6 reset best_hash", best_hash, '1);
      chk("R6 reset best_nonce", 256'(best_nonce), 256'(32'hFFFFFFFF));

      for (int i = 0; i < 19; i++) hm[i] = (32'h9E3779B9 * 32'(i + 1)) ^ 32'h5A5A0F0F;
      bs = 32'h0000_1000; cn = 6;
      low_two(lo1, lo2);
      {thi, tlo} = lo2;                       // exactly two qualify, one on equality
      load_regs();
      scan("A R1 R2 R4 R9", 7, 0);

      bs = 32'h0000_2000; cn = 5; {thi, tlo} = '1;
      wr(20, tlo); wr(21, thi); wr(22, bs); wr(23, 32'(cn));
      scan("B R10 busy writes", 5, 1);

      low_two(lo1, lo2);
      {thi, tlo} = lo1 - 64'd1;               // nothing qualifies
      wr(20, tlo); wr(21, thi);
      wr(19, 32'hDEADBEEF);
      for (int a = 24; a < 32; a++) wr(a, 32'hFFFF0000 | 32'(a));
      scan("C R6 R10 R9 none", 5, 0);

      hm[17] = hm[17] ^ 32'h0000_0100; wr(17, hm[17]);
      bs = 32'h0000_3000; cn = 4; {thi, tlo} = '1;
      wr(20, tlo); wr(21, thi); wr(22, bs); wr(23, 32'(cn));
      scan("D R9 R2 tail word", 4, 0);

      hm[5] = hm[5] + 32'd1; wr(5, hm[5]);
      scan("E R9 R1 head word", 5, 0);

      cn = 0; wr(23, 0);
      scan("F R11 empty", 0, 0);

      bs = 32'hFFFF_FFFD; cn = 5;
      wr(22, bs); wr(23, 32'(cn));
      scan("G R12 wrap", 5, 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule